// File: doc/BRIEF.md
# Precise Pipeline Exception Arbiter

This block follows fault conditions as instructions move through a five-stage in-order pipeline (fetch, decode, execute, memory access, write-back). Each instruction enters the block's tracking state at fetch. A fetch-side translation miss, raised in fetch, is attached to the instruction at once. A reserved-opcode fault, raised in decode, is attached when the instruction leaves decode. Both flags then travel with the instruction.

A fault is committed only when its instruction reaches the memory-access stage. That is the point where the instruction becomes the oldest one that can still fault, and where a data-side translation miss is raised. Because faults are committed at a single stage, they are taken in program order even when a younger instruction's fault was raised earlier. When a fault is taken, the block gives a one-cycle taken pulse, a cause code, a restart PC and a flush pulse. It also clears every younger tracked instruction and the flags it carries.

A delayed branch and its delay-slot instruction are never split. A fault on the slot instruction restarts at the branch, so both instructions run again. A fetch or decode fault carried by the slot is taken while the branch is still in the memory-access stage, before the branch writes back.

Top module: `pexc_arbiter`

## Requirements
- R1: After reset, exc_taken_o, flush_o and exc_cause_o are all 0.
- R2: Timing and pulse width.
  - An instruction presented at fetch in cycle t is in the memory-access stage in cycle t+3.
  - A fault committed there shows on exc_taken_o after the clock edge that ends that cycle.
  - exc_taken_o is high for exactly one cycle.
- R3: Faults are taken in program order.
  - With a data miss on instruction n, a fetch miss on n+1 and a reserved opcode on n+2, the first pass takes the data miss on n.
  - After the faults are cleared one by one and the sequence is replayed, the fetch miss on n+1 is taken next, then the reserved opcode on n+2.
- R4: Cause codes on exc_cause_o: 2'b01 is a fetch translation miss, 2'b10 is a data translation miss, 2'b11 is a reserved opcode. The code is 2'b00 in every cycle without a taken pulse.
- R5: For a fault on an instruction that is not a delay-slot instruction, exc_pc_o is that instruction's own PC.
- R6: For any fault on a delay-slot instruction, exc_pc_o is the PC of the delayed branch before it. The slot instruction is the one fetched directly after the instruction that id_dbranch_i marks while it is in decode. An instruction after the slot uses its own PC.
- R7: A fetch-miss or reserved-opcode fault carried by a delay-slot instruction is taken in the cycle in which the branch is in the memory-access stage, one cycle before the slot instruction arrives there.
- R8: On a taken fault, flush_o pulses together with exc_taken_o. No instruction that was in flight at that moment produces a later taken pulse.
- R9: When one instruction carries several faults, the earliest detected one is reported: fetch miss over reserved opcode over data miss.
- R10: Fault flags that arrive while the matching stage holds no valid instruction are ignored and produce no taken pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| if_valid_i | input | 1 | A valid instruction is in fetch this cycle |
| if_pc_i | input | PC_W | PC of the instruction in fetch |
| if_itlb_miss_i | input | 1 | Fetch-side translation miss for the instruction in fetch |
| id_rsvd_i | input | 1 | Instruction in decode has a reserved opcode |
| id_dbranch_i | input | 1 | Instruction in decode is a delayed branch |
| ma_dtlb_miss_i | input | 1 | Data-side translation miss for the instruction in memory access |
| exc_taken_o | output | 1 | One-cycle pulse: a fault is taken |
| exc_cause_o | output | 2 | Cause code of the taken fault, 0 otherwise |
| exc_pc_o | output | PC_W | Restart PC of the taken fault |
| flush_o | output | 1 | Squash fetch, decode, execute and memory access |

## Verification
The bench builds the block with PC_W set to 16, which keeps the restart PCs short and easy to read in failure lines. Every behaviour depends only on the three-stage carry from fetch to memory access, so the narrower PC changes nothing else. At that width the bench can replay the three-instruction scenario pass by pass and check the taken order. It also places faults on a branch, its delay slot and the instruction after the slot to separate restart at the branch from restart at the instruction's own PC.

// File: rtl/pexc_pkg.sv
package pexc_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_ITLB = 2'b01,
        CAUSE_DTLB = 2'b10,
        CAUSE_RSVD = 2'b11
    } cause_e;

endpackage

// File: rtl/pexc_track.sv
// Carries each instruction's PC, branch/slot markers and pending cause
// from fetch through decode and execute to the memory-access stage.
module pexc_track #(
    parameter int PC_W  = 32,
    parameter int REC_W = 2 * PC_W + 5
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  flush_i,
    input  logic                  if_valid_i,
    input  logic [PC_W-1:0]       if_pc_i,
    input  logic                  if_itlb_miss_i,
    input  logic                  id_rsvd_i,
    input  logic                  id_dbranch_i,
    output logic                  id_vld_o,
    output logic                  ex_vld_o,
    output logic                  ex_slot_o,
    output pexc_pkg::cause_e      ex_cause_o,
    output logic [REC_W-1:0]      ma_rec_o
);
    import pexc_pkg::*;

    typedef struct packed {
        logic            vld;
        logic [PC_W-1:0] pc;
        cause_e          cause;
        logic            brn;
        logic            slot;
        logic [PC_W-1:0] bpc;
    } rec_t;

    typedef struct packed {
        rec_t id;
        rec_t ex;
        rec_t ma;
    } st_t;

    localparam rec_t REC_EMPTY = '{vld: 1'b0, pc: '0, cause: CAUSE_NONE,
                                   brn: 1'b0, slot: 1'b0, bpc: '0};

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        // fetch -> decode: capture fetch fault and delay-slot marker
        st_d.id.vld   = if_valid_i;
        st_d.id.pc    = if_pc_i;
        st_d.id.cause = (if_valid_i && if_itlb_miss_i) ? CAUSE_ITLB : CAUSE_NONE;
        st_d.id.brn   = 1'b0;
        st_d.id.slot  = if_valid_i && st_q.id.vld && id_dbranch_i;
        st_d.id.bpc   = st_q.id.pc;

        // decode -> execute: add reserved-opcode fault unless one is carried
        st_d.ex     = st_q.id;
        st_d.ex.brn = st_q.id.vld && id_dbranch_i;
        if (st_q.id.vld && (st_q.id.cause == CAUSE_NONE) && id_rsvd_i) begin
            st_d.ex.cause = CAUSE_RSVD;
        end

        // execute -> memory access
        st_d.ma = st_q.ex;

        // taken fault: drop every in-flight instruction and its flags
        if (flush_i) begin
            st_d.id = REC_EMPTY;
            st_d.ex = REC_EMPTY;
            st_d.ma = REC_EMPTY;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{id: REC_EMPTY, ex: REC_EMPTY, ma: REC_EMPTY};
        end else begin
            st_q <= st_d;
        end
    end

    assign id_vld_o   = st_q.id.vld;
    assign ex_vld_o   = st_q.ex.vld;
    assign ex_slot_o  = st_q.ex.slot;
    assign ex_cause_o = st_q.ex.cause;
    assign ma_rec_o   = st_q.ma;

endmodule

// File: rtl/pexc_select.sv
// Decides, from the memory-access record and the execute slot state,
// whether a fault is committed this cycle, its cause and restart PC.
module pexc_select #(
    parameter int PC_W  = 32,
    parameter int REC_W = 2 * PC_W + 5
) (
    input  logic [REC_W-1:0]  ma_rec_i,
    input  logic              ma_dtlb_miss_i,
    input  logic              ex_vld_i,
    input  logic              ex_slot_i,
    input  pexc_pkg::cause_e  ex_cause_i,
    output logic              take_o,
    output pexc_pkg::cause_e  cause_o,
    output logic [PC_W-1:0]   pc_o
);
    import pexc_pkg::*;

    typedef struct packed {
        logic            vld;
        logic [PC_W-1:0] pc;
        cause_e          cause;
        logic            brn;
        logic            slot;
        logic [PC_W-1:0] bpc;
    } rec_t;

    rec_t   ma;
    cause_e ma_cause;

    assign ma = ma_rec_i;

    always_comb begin
        // carried fault is older in detection than the data miss
        ma_cause = ma.cause;
        if ((ma.cause == CAUSE_NONE) && ma_dtlb_miss_i) begin
            ma_cause = CAUSE_DTLB;
        end

        take_o  = 1'b0;
        cause_o = CAUSE_NONE;
        pc_o    = ma.pc;

        if (ma.vld && (ma_cause != CAUSE_NONE)) begin
            take_o  = 1'b1;
            cause_o = ma_cause;
            pc_o    = ma.slot ? ma.bpc : ma.pc;
        end else if (ma.vld && ma.brn && ex_vld_i && ex_slot_i &&
                     (ex_cause_i != CAUSE_NONE)) begin
            // slot fault taken before the branch leaves: restart at branch
            take_o  = 1'b1;
            cause_o = ex_cause_i;
            pc_o    = ma.pc;
        end
    end

endmodule

// File: rtl/pexc_arbiter.sv
module pexc_arbiter #(
    parameter int PC_W = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            if_valid_i,
    input  logic [PC_W-1:0] if_pc_i,
    input  logic            if_itlb_miss_i,
    input  logic            id_rsvd_i,
    input  logic            id_dbranch_i,
    input  logic            ma_dtlb_miss_i,
    output logic            exc_taken_o,
    output logic [1:0]      exc_cause_o,
    output logic [PC_W-1:0] exc_pc_o,
    output logic            flush_o
);
    import pexc_pkg::*;

    localparam int REC_W = 2 * PC_W + 5;

    typedef struct packed {
        logic            taken;
        cause_e          cause;
        logic [PC_W-1:0] pc;
    } out_t;

    logic             trk_id_vld;
    logic             trk_ex_vld;
    logic             trk_ex_slot;
    cause_e           trk_ex_cause;
    logic [REC_W-1:0] trk_ma_rec;
    logic             trk_ma_vld;
    logic             sel_take;
    cause_e           sel_cause;
    logic [PC_W-1:0]  sel_pc;

    out_t out_d, out_q;

    pexc_track #(.PC_W(PC_W), .REC_W(REC_W)) u_track (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .flush_i        (sel_take),
        .if_valid_i     (if_valid_i),
        .if_pc_i        (if_pc_i),
        .if_itlb_miss_i (if_itlb_miss_i),
        .id_rsvd_i      (id_rsvd_i),
        .id_dbranch_i   (id_dbranch_i),
        .id_vld_o       (trk_id_vld),
        .ex_vld_o       (trk_ex_vld),
        .ex_slot_o      (trk_ex_slot),
        .ex_cause_o     (trk_ex_cause),
        .ma_rec_o       (trk_ma_rec)
    );

    pexc_select #(.PC_W(PC_W), .REC_W(REC_W)) u_select (
        .ma_rec_i       (trk_ma_rec),
        .ma_dtlb_miss_i (ma_dtlb_miss_i),
        .ex_vld_i       (trk_ex_vld),
        .ex_slot_i      (trk_ex_slot),
        .ex_cause_i     (trk_ex_cause),
        .take_o         (sel_take),
        .cause_o        (sel_cause),
        .pc_o           (sel_pc)
    );

    // valid bit is the top field of the record
    assign trk_ma_vld = trk_ma_rec[REC_W-1];

    always_comb begin
        out_d       = out_q;
        out_d.taken = sel_take;
        out_d.cause = sel_take ? sel_cause : CAUSE_NONE;
        if (sel_take) begin
            out_d.pc = sel_pc;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '{taken: 1'b0, cause: CAUSE_NONE, pc: '0};
        end else begin
            out_q <= out_d;
        end
    end

    assign exc_taken_o = out_q.taken;
    assign exc_cause_o = out_q.cause;
    assign exc_pc_o    = out_q.pc;
    assign flush_o     = out_q.taken;

endmodule

// File: rtl/pexc_arbiter_chk.sv
module pexc_arbiter_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       exc_taken_o,
    input logic [1:0] exc_cause_o,
    input logic       flush_o,
    input logic       id_vld,
    input logic       ex_vld,
    input logic       ma_vld
);

    p_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_taken_o |=> !exc_taken_o);

    p_cause_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_taken_o |-> (exc_cause_o != 2'b00));

    p_cause_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !exc_taken_o |-> (exc_cause_o == 2'b00));

    p_flush_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_taken_o |-> (flush_o && !id_vld && !ex_vld && !ma_vld));

    p_origin_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_taken_o |-> $past(ma_vld));

endmodule

bind pexc_arbiter pexc_arbiter_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exc_taken_o (exc_taken_o),
    .exc_cause_o (exc_cause_o),
    .flush_o     (flush_o),
    .id_vld      (trk_id_vld),
    .ex_vld      (trk_ex_vld),
    .ma_vld      (trk_ma_vld)
);

// File: tb/pexc_arbiter_tb_top.sv
`timescale 1ns/1ps
module pexc_arbiter_tb_top;

    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          if_valid = 1'b0;
    logic [PW-1:0] if_pc = '0;
    logic          if_itlb = 1'b0;
    logic          id_rsvd = 1'b0;
    logic          id_dbr = 1'b0;
    logic          ma_dtlb = 1'b0;
    logic          exc_taken;
    logic [1:0]    exc_cause;
    logic [PW-1:0] exc_pc;
    logic          flush;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [PW-1:0] p_pc   [8];
    bit            p_itlb [8];
    bit            p_rsvd [8];
    bit            p_dtlb [8];
    bit            p_dbr  [8];

    always #10 clk = ~clk;

    pexc_arbiter #(.PC_W(PW)) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .if_valid_i     (if_valid),
        .if_pc_i        (if_pc),
        .if_itlb_miss_i (if_itlb),
        .id_rsvd_i      (id_rsvd),
        .id_dbranch_i   (id_dbr),
        .ma_dtlb_miss_i (ma_dtlb),
        .exc_taken_o    (exc_taken),
        .exc_cause_o    (exc_cause),
        .exc_pc_o       (exc_pc),
        .flush_o        (flush)
    );

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_prog(input logic [PW-1:0] base);
        for (int i = 0; i < 8; i++) begin
            p_pc[i]   = base + PW'(2 * i);
            p_itlb[i] = 1'b0;
            p_rsvd[i] = 1'b0;
            p_dtlb[i] = 1'b0;
            p_dbr[i]  = 1'b0;
        end
    endtask

    // Issue cnt instructions starting at index first, one per cycle.
    // Returns the first taken fault, the loop cycle it was seen after,
    // and how many further taken pulses followed.
    task automatic run_prog(input int first, input int cnt,
                            output bit got, output int cause,
                            output int pc, output int when,
                            output int extra, output int fl);
        bit stop = 1'b0;
        got = 1'b0; cause = 0; pc = 0; when = -1; extra = 0; fl = 0;
        for (int c = 0; c < cnt + 8; c++) begin
            if_valid = 1'b0; if_pc = '0; if_itlb = 1'b0;
            id_rsvd = 1'b0; id_dbr = 1'b0; ma_dtlb = 1'b0;
            if (!stop) begin
                if (c < cnt) begin
                    if_valid = 1'b1;
                    if_pc    = p_pc[first + c];
                    if_itlb  = p_itlb[first + c];
                end
                if (c >= 1 && c - 1 < cnt) begin
                    id_rsvd = p_rsvd[first + c - 1];
                    id_dbr  = p_dbr[first + c - 1];
                end
                if (c >= 3 && c - 3 < cnt) begin
                    ma_dtlb = p_dtlb[first + c - 3];
                end
            end
            @(posedge clk);
            @(negedge clk);
            if (exc_taken) begin
                if (!got) begin
                    got = 1'b1; cause = int'(exc_cause); pc = int'(exc_pc);
                    when = c; fl = int'(flush); stop = 1'b1;
                end else begin
                    extra++;
                end
            end
        end
        if_valid = 1'b0; if_itlb = 1'b0; id_rsvd = 1'b0;
        id_dbr = 1'b0; ma_dtlb = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "taken after reset", int'(exc_taken), 0);
        check("R1", "flush after reset", int'(flush), 0);
        check("R1", "cause after reset", int'(exc_cause), 0);
    endtask

    task automatic t_order();
        bit g; int c, p, w, x, f;
        clear_prog(16'h0100);
        p_dtlb[0] = 1'b1; p_itlb[1] = 1'b1; p_rsvd[2] = 1'b1;
        // pass 1: oldest fault wins although n+1 flagged it earlier
        run_prog(0, 3, g, c, p, w, x, f);
        check("R3", "pass1 taken", int'(g), 1);
        check("R3", "pass1 cause dtlb", c, 2);
        check("R5", "pass1 pc", p, 16'h0100);
        check("R2", "pass1 cycle", w, 3);
        check("R8", "pass1 flush", f, 1);
        check("R8", "pass1 no younger fault", x, 0);
        // pass 2: n re-runs clean, n+1 fetch miss is next
        p_dtlb[0] = 1'b0;
        run_prog(0, 3, g, c, p, w, x, f);
        check("R3", "pass2 cause itlb", c, 1);
        check("R5", "pass2 pc", p, 16'h0102);
        check("R2", "pass2 cycle", w, 4);
        check("R8", "pass2 no younger fault", x, 0);
        // pass 3: restart at n+1, reserved opcode on n+2 last
        p_itlb[1] = 1'b0;
        run_prog(1, 2, g, c, p, w, x, f);
        check("R3", "pass3 cause rsvd", c, 3);
        check("R5", "pass3 pc", p, 16'h0104);
        check("R2", "pass3 cycle", w, 4);
        // pass 4: all clean
        p_rsvd[2] = 1'b0;
        run_prog(0, 3, g, c, p, w, x, f);
        check("R3", "pass4 no fault", int'(g), 0);
    endtask

    task automatic t_slot();
        bit g; int c, p, w, x, f;
        clear_prog(16'h0200);
        p_dbr[0] = 1'b1; p_rsvd[1] = 1'b1;
        run_prog(0, 4, g, c, p, w, x, f);
        check("R7", "slot rsvd cause", c, 3);
        check("R6", "slot rsvd restart at branch", p, 16'h0200);
        check("R7", "slot rsvd taken at branch MA", w, 3);
        check("R2", "slot rsvd single pulse", x, 0);

        clear_prog(16'h0200);
        p_dbr[0] = 1'b1; p_itlb[1] = 1'b1;
        run_prog(0, 4, g, c, p, w, x, f);
        check("R7", "slot itlb cause", c, 1);
        check("R6", "slot itlb restart at branch", p, 16'h0200);
        check("R7", "slot itlb taken at branch MA", w, 3);

        clear_prog(16'h0200);
        p_dbr[0] = 1'b1; p_dtlb[1] = 1'b1;
        run_prog(0, 4, g, c, p, w, x, f);
        check("R4", "slot dtlb cause", c, 2);
        check("R6", "slot dtlb restart at branch", p, 16'h0200);
        check("R2", "slot dtlb cycle", w, 4);

        clear_prog(16'h0200);
        p_dbr[0] = 1'b1; p_dtlb[2] = 1'b1;
        run_prog(0, 4, g, c, p, w, x, f);
        check("R6", "after-slot uses own pc", p, 16'h0204);
        check("R2", "after-slot cycle", w, 5);
    endtask

    task automatic t_prio();
        bit g; int c, p, w, x, f;
        clear_prog(16'h0300);
        p_itlb[1] = 1'b1; p_rsvd[1] = 1'b1; p_dtlb[1] = 1'b1;
        run_prog(0, 3, g, c, p, w, x, f);
        check("R9", "itlb over rsvd and dtlb", c, 1);
        check("R5", "prio pc", p, 16'h0302);

        clear_prog(16'h0300);
        p_rsvd[0] = 1'b1; p_dtlb[0] = 1'b1;
        run_prog(0, 2, g, c, p, w, x, f);
        check("R9", "rsvd over dtlb", c, 3);
        check("R4", "cause idle after pulse", int'(exc_cause), 0);
    endtask

    task automatic t_idle_flags();
        int seen = 0;
        if_valid = 1'b0; if_itlb = 1'b1; id_rsvd = 1'b1;
        id_dbr = 1'b1; ma_dtlb = 1'b1;
        for (int c = 0; c < 8; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (exc_taken) seen++;
        end
        if_itlb = 1'b0; id_rsvd = 1'b0; id_dbr = 1'b0; ma_dtlb = 1'b0;
        check("R10", "flags without instruction ignored", seen, 0);
        check("R10", "cause stays idle", int'(exc_cause), 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_order();
        t_slot();
        t_prio();
        t_idle_flags();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule